// File: doc/BRIEF.md
# Program Counter Skip Sequencer

This block keeps the program counter and the memory-address register of a small 12-bit accumulator machine. It walks each instruction through four time states. In the first state it moves the PC forward to the word after the one being fetched. In the third state it may record a skip condition or take a jump target. In the fourth state it prepares the address of the next fetch. The surrounding execute logic supplies the skip condition, the jump request and its target, and the interrupt request. Memory, decode and the arithmetic datapath sit outside the block.

Every PC and address update goes through one incrementer. The incrementer's carry-in is the only source of the extra step. A recorded skip moves the next fetch address forward by exactly one word. It does not check whether the instruction being passed over is one word or two. When an interrupt is pending at the fourth state, the next fetch address is set to zero and a flag tells the instruction register to accept a subroutine-call in place of the fetched word.

Top module: `pc_skip_seq`

## Requirements
- R1: With `run` high, `tstate` advances 0→1→2→3→0 on each clock (0=TS1, 1=TS2, 2=TS3, 3=TS4). With `run` low, `tstate`, `pc`, `mar` and `force_call` hold their values.
- R2: On a TS1 advance, `pc` becomes `mar` + 1 modulo 4096, and the recorded skip is cleared.
- R3: A skip is recorded only when `skip_req` is high on the TS3 advance. A `skip_req` in any other state has no effect on the next address.
- R4: When `load_req` is high on the TS3 advance, `pc` and `mar` both take `load_target`. A `load_req` in any other state leaves `pc` and `mar` unchanged.
- R5: On a TS4 advance with no interrupt and no recorded skip, `mar` becomes `pc`.
- R6: On a TS4 advance with a recorded skip and no interrupt, `mar` becomes `pc` + 1 modulo 4096. This is a single-word advance.
- R7: When a load and a skip occur in the same instruction, the next `mar` is `load_target` + 1 modulo 4096.
- R8: On a TS4 advance with an interrupt pending, `mar` becomes 0 and `force_call` goes high. `force_call` stays high until the next advance, which clears it.
- R9: An `irq` pulse in any time state is held and takes effect at the next TS4 advance. It is then consumed.
- R10: A synchronous reset (`rst` high) sets `pc`=0, `mar`=0, `tstate`=0 and `force_call`=0, and clears both the held interrupt and the skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Advance one time state on this clock |
| skip_req | input | 1 | Skip condition from the execute logic |
| load_req | input | 1 | Jump / PC-load request |
| load_target | input | 12 | Jump target address |
| irq | input | 1 | Interrupt request |
| pc | output | 12 | Program counter |
| mar | output | 12 | Memory-address register |
| tstate | output | 2 | Current time state, 0..3 |
| force_call | output | 1 | Substitute a subroutine-call into the instruction register |

## Verification
Two actions can land on the same instruction. A jump load and a skip can both occur, so the skip increment must be applied to the loaded target rather than the old PC. An interrupt can also coincide with a skip or a load, and then it must win and clear the address. The bench sweeps every placement of skip, load and interrupt pulses across the four time states, including all of them in one instruction. It computes the expected address arithmetically and checks it at each state boundary.

// File: rtl/pc_skip_seq.sv
module pc_skip_seq #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          skip_req,
  input  logic          load_req,
  input  logic [AW-1:0] load_target,
  input  logic          irq,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] mar,
  output logic [1:0]    tstate,
  output logic          force_call
);
  localparam logic [1:0] TS1 = 2'd0;
  localparam logic [1:0] TS2 = 2'd1;
  localparam logic [1:0] TS3 = 2'd2;
  localparam logic [1:0] TS4 = 2'd3;

  logic          skip_ff;
  logic          irq_pend;
  logic          irq_any;
  logic [AW-1:0] add_base;
  logic          add_cin;
  logic [AW-1:0] add_sum;

  assign irq_any = irq_pend | irq;

  always_comb begin
    case (tstate)
      TS1:     begin add_base = mar;         add_cin = 1'b1;    end
      TS3:     begin add_base = load_target; add_cin = 1'b0;    end
      default: begin add_base = pc;          add_cin = skip_ff; end
    endcase
  end

  assign add_sum = add_base + {{(AW-1){1'b0}}, add_cin};

  always_ff @(posedge clk) begin
    if (rst) begin
      pc         <= '0;
      mar        <= '0;
      tstate     <= TS1;
      skip_ff    <= 1'b0;
      irq_pend   <= 1'b0;
      force_call <= 1'b0;
    end else begin
      if (irq) irq_pend <= 1'b1;
      if (run) begin
        tstate     <= tstate + 2'd1;
        force_call <= 1'b0;
        case (tstate)
          TS1: begin
            skip_ff <= 1'b0;
            pc      <= add_sum;
          end
          TS3: begin
            if (skip_req) skip_ff <= 1'b1;
            if (load_req) begin
              pc  <= add_sum;
              mar <= add_sum;
            end
          end
          TS4: begin
            if (irq_any) begin
              mar        <= '0;
              force_call <= 1'b1;
              irq_pend   <= 1'b0;
            end else begin
              mar <= add_sum;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R1
  ts_order_chk: assert property (@(posedge clk) disable iff (rst)
    run |=> tstate == $past(tstate) + 2'd1);

  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(pc) && $stable(mar) && $stable(tstate) && $stable(force_call));

  // R2
  fetch_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (run && tstate == TS1) |=> pc == $past(mar) + 1'b1);

  // R3
  skip_only_ts3_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(skip_ff) |-> $past(tstate) == TS3);

  // R5
  plain_next_chk: assert property (@(posedge clk) disable iff (rst)
    (run && tstate == TS4 && !irq_any && !skip_ff) |=> mar == $past(pc));

  // R8
  irq_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (run && tstate == TS4 && irq_any) |=> mar == '0 && force_call);

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !(run && tstate == TS4)) |=> irq_pend);
endmodule

// File: tb/sim_pc_skip_seq.sv
module sim_pc_skip_seq;
  logic clk = 1'b0;
  logic rst, run, skip_req, load_req, irq;
  logic [11:0] load_target;
  logic [11:0] pc, mar;
  logic [1:0]  tstate;
  logic        force_call;

  int errors = 0;
  int checks = 0;
  logic [11:0] e_pc, e_mar;
  logic        e_fc;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  pc_skip_seq #(.AW(12)) u0 (
    .clk(clk), .rst(rst), .run(run), .skip_req(skip_req), .load_req(load_req),
    .load_target(load_target), .irq(irq), .pc(pc), .mar(mar),
    .tstate(tstate), .force_call(force_call)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit r, input bit sk, input bit ld, input logic [11:0] t, input bit ir);
    run = r; skip_req = sk; load_req = ld; load_target = t; irq = ir;
    @(posedge clk);
    @(negedge clk);
    run = 1'b0; skip_req = 1'b0; load_req = 1'b0; irq = 1'b0;
  endtask

  // sk_ts/ld_ts/ir_ts: state index (0..3) that carries the pulse, -1 for none
  task automatic instr(input int sk_ts, input int ld_ts, input int ir_ts,
                       input logic [11:0] tgt, input bit stall);
    bit sk_eff, ld_eff, ir_eff;
    string mtag;
    sk_eff = (sk_ts == 2);
    ld_eff = (ld_ts == 2);
    ir_eff = (ir_ts >= 0);
    for (int s = 0; s < 4; s++) begin
      cyc(1'b1, sk_ts == s, ld_ts == s, tgt, ir_ts == s);
      chk("R1 tstate", tstate, (s + 1) % 4);
      if (s == 0) begin
        e_pc = e_mar + 12'd1;
        chk("R2 pc after fetch", pc, e_pc);
        chk("R8 force_call cleared", force_call, 0);
      end
      if (s == 1 && stall) begin
        for (int k = 0; k < 3; k++) begin
          cyc(1'b0, 1'b0, 1'b0, tgt, 1'b0);
          chk("R1 stall tstate", tstate, 2);
          chk("R1 stall pc", pc, e_pc);
          chk("R1 stall mar", mar, e_mar);
        end
      end
      if (s == 2) begin
        if (ld_eff) begin e_pc = tgt; e_mar = tgt; end
        chk("R4 pc after TS3", pc, e_pc);
        chk("R4 mar after TS3", mar, e_mar);
      end
      if (s == 3) begin
        if (ir_eff) begin
          e_mar = 12'd0; e_fc = 1'b1;
          mtag = (ir_ts == 3) ? "R8 irq mar" : "R9 held irq mar";
        end else begin
          e_mar = e_pc + {11'd0, sk_eff}; e_fc = 1'b0;
          if (sk_eff && ld_eff) mtag = "R7 load+skip mar";
          else if (sk_eff) mtag = "R6 skip mar";
          else if (sk_ts >= 0) mtag = "R3 ignored skip mar";
          else mtag = "R5 plain mar";
        end
        chk(mtag, mar, e_mar);
        chk("R8 force_call", force_call, e_fc);
      end
    end
  endtask

  initial begin
    rst = 1'b1; run = 1'b0; skip_req = 1'b0; load_req = 1'b0; irq = 1'b0; load_target = '0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    chk("R10 pc", pc, 0);
    chk("R10 mar", mar, 0);
    chk("R10 tstate", tstate, 0);
    chk("R10 force_call", force_call, 0);
    e_pc = '0; e_mar = '0; e_fc = 1'b0;
    for (int a = -1; a < 4; a++)
      for (int b = -1; b < 4; b++)
        for (int c = -1; c < 4; c++)
          instr(a, b, c, 12'(((a + 2) * 811 + (b + 2) * 97 + (c + 2) * 1301) % 4096), (a + b + c) % 3 == 0);
    instr(2, 2, -1, 12'd4095, 1'b0);
    instr(-1, -1, -1, 12'd0, 1'b0);
    instr(2, 2, -1, 12'd4094, 1'b0);
    instr(2, -1, -1, 12'd0, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10 re-reset mar", mar, 0);
    chk("R10 re-reset tstate", tstate, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule